// File: doc/BRIEF.md
# Two-Clock Phase Delay Meter

This block measures how far the rising edge of a second clock lags the rising edge of a first clock, where both clocks share the same nominal frequency. It samples both clocks with a fast local clock that runs twenty times faster than the measured clocks, so one tick of the fast clock is one twentieth of a measured period. A result is therefore a lag between zero and nineteen ticks.

A start command begins a batch. In each interval the meter counts fast ticks from a rising edge of the first clock to the next rising edge of the second clock. After a programmed number of intervals it divides the total by the batch size, rounds to the nearest tick, and presents the mean with a one-cycle strobe. In the same cycle it raises or clears a flag that says whether further delay-line tuning is pointless. The flag is set when the mean is below the larger of one tick, which is the meter's resolution, and the delay-line step. The tuning controller uses the mean to set a delay line on one of the clocks, and it stops iterating once the flag is set.

Top module: `clk_skew_meter`

## Requirements
- R1: While reset is asserted and after its release, `mean_ticks` is 0 and `mean_valid` and `tune_done` are low, until the first result.
- R2: Each interval sample equals the number of fast-clock cycles between the synchronized rising edge of `meas_a` and the next synchronized rising edge of `meas_b`. Both inputs pass through identical two-flop synchronizers. Edges that are detected in the same cycle give a sample of 0, and a lag of 19 ticks gives 19.
- R3: An interval count saturates at RATIO (20), and a saturated count is recorded as 0. A sample never exceeds RATIO-1. When `meas_b` rises only every other period, in phase with `meas_a`, the mean is 0.
- R4: The mean is the sum of SAMPLES (100) consecutive samples divided by SAMPLES and rounded to nearest, with halves rounded up. For example, samples alternating 3 and 4 give 4, and samples alternating 1 and 2 give 2.
- R5: `mean_valid` is high for exactly one cycle per completed batch. `mean_ticks` changes only in that cycle.
- R6: A `start` that arrives while a batch is being measured or divided is ignored. That batch produces exactly one result, and it is unaffected.
- R7: In the `mean_valid` cycle, `tune_done` is 1 when the mean is strictly below max(1, `step_ticks`) and 0 otherwise. `step_ticks` is taken from the cycle before the strobe. `tune_done` holds its value until the next result.
- R8: No `mean_valid` is produced without a preceding accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measuring clock (RATIO times the measured frequency) |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_a | input | 1 | First measured clock; starts each interval |
| meas_b | input | 1 | Second measured clock; ends each interval |
| start | input | 1 | One-cycle request to begin a batch |
| step_ticks | input | 5 | Delay-line step in fast ticks |
| mean_ticks | output | 5 | Rounded mean lag in fast ticks |
| mean_valid | output | 1 | One-cycle strobe for a new mean |
| tune_done | output | 1 | Residual lag is below the larger resolution |

## Verification
The start and the stop of an interval can fall in the same cycle. When the two clocks are exactly in phase, both synchronized edges arrive together, and the interval must close at once with a sample of zero instead of staying open for a full period. The bench creates this by driving both clocks with zero offset, and separately by driving the second clock at half rate so that every other interval saturates. In both cases a correct result is a mean of exactly 0. A design that opens and closes on coincident edges in the wrong order, or that keeps a saturated count of 20, reports a mean near 20 instead.

// File: rtl/skew_meter_pkg.sv
package skew_meter_pkg;
  typedef enum logic [1:0] {
    SM_IDLE = 2'd0,
    SM_MEAS = 2'd1,
    SM_DIV  = 2'd2
  } sm_state_e;
endpackage

// File: rtl/skew_edge_sync.sv
module skew_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], d_in};
    last_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/skew_interval.sv
module skew_interval #(
  parameter int RATIO = 20,
  parameter int CW    = $clog2(RATIO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rise_a,
  input  logic          rise_b,
  output logic [CW-1:0] smp,
  output logic          smp_vld
);
  localparam logic [CW-1:0] SAT = CW'(RATIO);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] inc;

  always_comb begin
    inc     = (cnt_q == SAT) ? cnt_q : cnt_q + CW'(1);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    smp     = '0;
    smp_vld = 1'b0;
    if (!en) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (!armed_q) begin
      if (rise_a) begin
        if (rise_b) begin
          smp_vld = 1'b1;
        end else begin
          armed_d = 1'b1;
          cnt_d   = '0;
        end
      end
    end else begin
      if (rise_b) begin
        smp_vld = 1'b1;
        smp     = (inc == SAT) ? '0 : inc;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/skew_mean_div.sv
module skew_mean_div #(
  parameter int SAMPLES = 100,
  parameter int AW      = 12,
  parameter int QW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] dividend,
  output logic [QW-1:0] quot,
  output logic          done
);
  localparam logic [AW-1:0] DIVISOR = AW'(SAMPLES);
  localparam logic [AW-1:0] HALF    = AW'(SAMPLES / 2);

  logic          busy_q, busy_d;
  logic [AW-1:0] rem_q, rem_d;
  logic [QW-1:0] q_q, q_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    q_d    = q_q;
    done_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      rem_d  = dividend + HALF;
      q_d    = '0;
    end else if (busy_q) begin
      if (rem_q >= DIVISOR) begin
        rem_d = rem_q - DIVISOR;
        q_d   = q_q + QW'(1);
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      q_q    <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      q_q    <= q_d;
      done_q <= done_d;
    end
  end

  assign quot = q_q;
  assign done = done_q;
endmodule

// File: rtl/clk_skew_meter.sv
module clk_skew_meter
  import skew_meter_pkg::*;
#(
  parameter int RATIO   = 20,
  parameter int SAMPLES = 100,
  parameter int SYNC    = 2,
  parameter int MW      = $clog2(RATIO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_a,
  input  logic          meas_b,
  input  logic          start,
  input  logic [MW-1:0] step_ticks,
  output logic [MW-1:0] mean_ticks,
  output logic          mean_valid,
  output logic          tune_done
);
  localparam int CW = MW;
  localparam int AW = $clog2(SAMPLES * RATIO + SAMPLES / 2 + 1);
  localparam int NW = $clog2(SAMPLES + 1);
  localparam logic [MW-1:0] RES = MW'(1);

  logic [1:0]    meas_in;
  logic [1:0]    rise;
  logic [CW-1:0] smp;
  logic          smp_vld;
  logic          div_go, div_done;
  logic [AW-1:0] div_in;
  logic [MW-1:0] quot;
  logic [MW-1:0] limit;

  sm_state_e     state_q, state_d;
  logic [NW-1:0] n_q, n_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [MW-1:0] mean_q, mean_d;
  logic          vld_q, vld_d;
  logic          done_q, done_d;

  assign meas_in = {meas_b, meas_a};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    skew_edge_sync #(.STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (meas_in[g]),
      .rise (rise[g])
    );
  end

  skew_interval #(.RATIO(RATIO), .CW(CW)) u_intv (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state_q == SM_MEAS),
    .rise_a (rise[0]),
    .rise_b (rise[1]),
    .smp    (smp),
    .smp_vld(smp_vld)
  );

  skew_mean_div #(.SAMPLES(SAMPLES), .AW(AW), .QW(MW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .dividend(div_in),
    .quot    (quot),
    .done    (div_done)
  );

  assign limit  = (step_ticks > RES) ? step_ticks : RES;
  assign div_in = acc_q + AW'(smp);

  always_comb begin
    state_d = state_q;
    n_d     = n_q;
    acc_d   = acc_q;
    div_go  = 1'b0;
    unique case (state_q)
      SM_IDLE: begin
        if (start) begin
          state_d = SM_MEAS;
          n_d     = '0;
          acc_d   = '0;
        end
      end
      SM_MEAS: begin
        if (smp_vld) begin
          acc_d = div_in;
          n_d   = n_q + NW'(1);
          if (n_q == NW'(SAMPLES - 1)) begin
            div_go  = 1'b1;
            state_d = SM_DIV;
          end
        end
      end
      SM_DIV: begin
        if (div_done) state_d = SM_IDLE;
      end
      default: state_d = SM_IDLE;
    endcase
    vld_d  = div_done;
    mean_d = div_done ? quot : mean_q;
    done_d = div_done ? (quot < limit) : done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SM_IDLE;
      n_q     <= '0;
      acc_q   <= '0;
      mean_q  <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      n_q     <= n_d;
      acc_q   <= acc_d;
      mean_q  <= mean_d;
      vld_q   <= vld_d;
      done_q  <= done_d;
    end
  end

  assign mean_ticks = mean_q;
  assign mean_valid = vld_q;
  assign tune_done  = done_q;
endmodule

// File: rtl/clk_skew_meter_chk.sv
module clk_skew_meter_chk #(
  parameter int RATIO = 20,
  parameter int MW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mean_valid,
  input logic [MW-1:0] mean_ticks,
  input logic          tune_done,
  input logic [MW-1:0] step_ticks,
  input logic          smp_vld,
  input logic [MW-1:0] smp
);
  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> (smp < MW'(RATIO))); // R3

  AST_MEAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid |-> (mean_ticks < MW'(RATIO))); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid |=> !mean_valid); // R5

  AST_MEAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mean_valid |-> $stable(mean_ticks)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mean_valid |-> $stable(tune_done)); // R7

  AST_DONE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    mean_valid |-> (tune_done == (mean_ticks <
      (($past(step_ticks) > MW'(1)) ? $past(step_ticks) : MW'(1))))); // R7
endmodule

bind clk_skew_meter clk_skew_meter_chk #(.RATIO(RATIO), .MW(MW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mean_valid(mean_valid),
  .mean_ticks(mean_ticks),
  .tune_done (tune_done),
  .step_ticks(step_ticks),
  .smp_vld   (smp_vld),
  .smp       (smp)
);

// File: tb/sim_clk_skew_meter.sv
module sim_clk_skew_meter;
  localparam int RATIO   = 20;
  localparam int SAMPLES = 100;
  localparam int MW      = $clog2(RATIO + 1);

  logic          clk, rst_n, start;
  logic          meas_a, meas_b;
  logic [MW-1:0] step_ticks, mean_ticks;
  logic          mean_valid, tune_done;

  typedef struct {
    int    mean;
    int    done;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, popped = 0;
  int ph = 0, d0 = 0, d1 = 0;
  bit half_rate = 0;
  bit prev_vld = 0;
  int last_done = 0;
  int dcur;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  clk_skew_meter #(.RATIO(RATIO), .SAMPLES(SAMPLES)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_a    (meas_a),
    .meas_b    (meas_b),
    .start     (start),
    .step_ticks(step_ticks),
    .mean_ticks(mean_ticks),
    .mean_valid(mean_valid),
    .tune_done (tune_done)
  );

  // Measured clocks: 20 fast cycles per period, B lags A by dcur ticks.
  always @(negedge clk) ph <= (ph == 2 * RATIO - 1) ? 0 : ph + 1;
  assign dcur   = (ph < RATIO) ? d0 : d1;
  assign meas_a = (ph % RATIO) < RATIO / 2;
  assign meas_b = half_rate ? (ph < RATIO / 2)
                            : (((ph % RATIO) + RATIO - dcur) % RATIO) < RATIO / 2;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_vld) begin
        check(mean_valid == 1'b0, "R5", "strobe wider than one cycle", int'(mean_valid), 0);
        check(int'(tune_done) == last_done, "R7", "flag not held", int'(tune_done), last_done);
      end
      if (mean_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "strobe without accepted start", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(mean_ticks) == e.mean, e.tag, "mean", int'(mean_ticks), e.mean);
          check(int'(tune_done) == e.done, "R7", "tune flag", int'(tune_done), e.done);
          popped = popped + 1;
        end
        last_done = int'(tune_done);
      end
      prev_vld = mean_valid;
    end
  end

  task automatic run(input int a0, input int a1, input bit hr, input int step,
                     input int exp_mean, input int exp_done, input string tag,
                     input bit extra_start);
    int target;
    exp_t e;
    @(negedge clk);
    d0 = a0; d1 = a1; half_rate = hr; step_ticks = MW'(step);
    repeat (60) @(negedge clk);
    e.mean = exp_mean; e.done = exp_done; e.tag = tag;
    exp_q.push_back(e);
    target = popped + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (500) @(negedge clk);
      start = 1'b1;  // R6: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 6000 && popped < target; i++) @(negedge clk);
    check(popped >= target, tag, "result timeout", popped, target);
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending expectations after idle", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; step_ticks = '0;
    repeat (3) @(negedge clk);
    check(mean_ticks == '0, "R1", "mean in reset", int'(mean_ticks), 0);
    check(mean_valid == 1'b0, "R1", "valid in reset", int'(mean_valid), 0);
    check(tune_done == 1'b0, "R1", "flag in reset", int'(tune_done), 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(mean_valid == 1'b0 && mean_ticks == '0, "R8", "idle after reset",
          int'(mean_ticks), 0);

    run(7, 7, 0, 8, 7, 1, "R2", 0);    // lag 7, below step 8
    run(7, 7, 0, 3, 7, 0, "R2", 0);    // lag 7, step 3: keep tuning
    run(0, 0, 0, 0, 0, 1, "R2", 0);    // coincident edges, floor of 1 tick
    run(19, 19, 0, 0, 19, 0, "R2", 0); // largest lag
    run(3, 4, 0, 4, 4, 0, "R4", 0);    // 3.5 rounds up, equal is not below
    run(1, 2, 0, 5, 2, 1, "R4", 0);    // 1.5 rounds up to 2
    run(2, 2, 0, 2, 2, 0, "R4", 0);    // exact, not below step
    run(0, 0, 1, 0, 0, 1, "R3", 0);    // half-rate B: saturated counts are 0
    run(5, 5, 0, 2, 5, 0, "R6", 1);    // extra start mid-batch ignored

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule